// File: doc/BRIEF.md
# Vector-to-Predicate Bit Spreader

This unit turns one slice of a wide vector register into a predicate value that carries one bit per vector byte. The caller names an element size (byte, halfword, word or doubleword) and a slice index. With N = vector_bytes / element_bytes, the unit takes the N packed vector bits that begin at bit position index × N. It then places slice bit i on the first predicate bit of element i. Every other predicate bit is cleared.

The vector length is a parameter. It is a multiple of 128 bits from 128 to 2048, and the predicate is one eighth of that width. At lengths that are not a power-of-two multiple of 128 bits, the packed slice can cross a 64-bit word boundary. The extraction is a single full-width shift, so a crossing needs no special path.

A one-cycle `start` pulse launches a conversion. The result is registered and shows up on the next cycle together with a one-cycle `done` pulse. An index that is too large for the chosen element size raises an illegal flag and produces an all-zero predicate.

Top module: `vec2pred_spread`

## Requirements
- R1: While reset is asserted, `done`, `idx_illegal` and every bit of `pred_out` are 0.
- R2: A `start` pulse in cycle t makes `done` high in cycle t+1 only. `done` is low in any cycle that does not follow a `start` cycle.
- R3: The element-size code is 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. For byte size with index 0, `pred_out` equals the low VLEN_BITS/8 bits of `vec_in`.
- R4: For halfword size, with N = VLEN_BITS/16, predicate bit 2i equals vector bit index×N + i, for i < N.
- R5: For word size, with N = VLEN_BITS/32, predicate bit 4i equals vector bit index×N + i.
- R6: For doubleword size, with N = VLEN_BITS/64, predicate bit 8i equals vector bit index×N + i.
- R7: Every predicate bit whose position is not a multiple of the element size in bytes is 0.
- R8: The legal index ranges are 0 for byte, 0..1 for halfword, 0..3 for word and 0..7 for doubleword. An index outside its range sets `idx_illegal` and makes `pred_out` all zero. A legal index clears `idx_illegal`.
- R9: A slice that crosses a 64-bit word boundary is extracted correctly. An example is doubleword index 6 at a 640-bit vector length, which uses bits 60..69.
- R10: In cycles that do not follow a `start`, `pred_out` and `idx_illegal` hold their values, whatever happens on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a conversion with the current inputs |
| vec_in | input | VLEN_BITS | Source vector value |
| elem_size | input | 2 | Element size code (0 byte, 1 half, 2 word, 3 double) |
| slice_idx | input | 3 | Slice index |
| done | output | 1 | One-cycle pulse marking a new result |
| pred_out | output | VLEN_BITS/8 | Predicate result |
| idx_illegal | output | 1 | Index out of range for the element size |

## Verification
The bench runs every size and index pair, legal or not, on two instances. One is 512 bits wide. The other is 640 bits wide, so that doubleword slices straddle a 64-bit word; a shifter cut into 64-bit lanes would return the wrong bits there. A scatter that used the wrong stride or left stale bits at non-leading positions would break the zero-fill check. A design that still produced a slice for an out-of-range index would show nonzero predicates with the flag clear. Idle cycles with scrambled inputs, and back-to-back starts, catch an output register with a missing enable or a `done` that stays high too long.

// File: rtl/vp_pkg.sv
package vp_pkg;
  typedef enum logic [1:0] {
    ES_BYTE = 2'd0,
    ES_HALF = 2'd1,
    ES_WORD = 2'd2,
    ES_DBL  = 2'd3
  } elem_size_e;

  localparam int unsigned IDX_W = 3;
endpackage

// File: rtl/vp_slice_shift.sv
// Selects the packed slice by shifting the whole vector right by index * N.
// A single full-width shift handles slices that straddle 64-bit words.
module vp_slice_shift
  import vp_pkg::*;
#(
  parameter int unsigned VLEN_BITS = 512
) (
  input  logic [VLEN_BITS-1:0]   vec_i,
  input  elem_size_e             es_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [VLEN_BITS/8-1:0] slice_o,
  output logic                   legal_o
);
  localparam int unsigned VBYTES = VLEN_BITS / 8;
  localparam int unsigned SHW    = $clog2(VLEN_BITS);
  localparam logic [SHW-1:0] N_HALF = SHW'(VBYTES / 2);
  localparam logic [SHW-1:0] N_WORD = SHW'(VBYTES / 4);
  localparam logic [SHW-1:0] N_DBL  = SHW'(VBYTES / 8);

  logic [SHW-1:0]       shamt;
  logic [VLEN_BITS-1:0] shifted;

  always_comb begin
    shamt   = '0;
    legal_o = 1'b0;
    unique case (es_i)
      ES_BYTE: begin
        legal_o = (idx_i == '0);
      end
      ES_HALF: begin
        legal_o = (idx_i[2:1] == 2'b00);
        shamt   = {SHW{idx_i[0]}} & N_HALF;
      end
      ES_WORD: begin
        legal_o = ~idx_i[2];
        shamt   = SHW'(idx_i[1:0]) * N_WORD;
      end
      ES_DBL: begin
        legal_o = 1'b1;
        shamt   = SHW'(idx_i) * N_DBL;
      end
      default: begin
        legal_o = 1'b0;
      end
    endcase
  end

  assign shifted = vec_i >> shamt;
  assign slice_o = shifted[VBYTES-1:0];
endmodule

// File: rtl/vp_bit_scatter.sv
// Places packed slice bit i on predicate bit i * element_bytes; zero elsewhere.
module vp_bit_scatter
  import vp_pkg::*;
#(
  parameter int unsigned VBYTES = 64
) (
  input  logic [VBYTES-1:0] slice_i,
  input  elem_size_e        es_i,
  output logic [VBYTES-1:0] pred_o
);
  for (genvar j = 0; j < VBYTES; j++) begin : g_pos
    logic from_half, from_word, from_dbl;

    if ((j % 2) == 0) begin : g_h
      assign from_half = slice_i[j/2];
    end else begin : g_hz
      assign from_half = 1'b0;
    end

    if ((j % 4) == 0) begin : g_w
      assign from_word = slice_i[j/4];
    end else begin : g_wz
      assign from_word = 1'b0;
    end

    if ((j % 8) == 0) begin : g_d
      assign from_dbl = slice_i[j/8];
    end else begin : g_dz
      assign from_dbl = 1'b0;
    end

    always_comb begin
      unique case (es_i)
        ES_BYTE: pred_o[j] = slice_i[j];
        ES_HALF: pred_o[j] = from_half;
        ES_WORD: pred_o[j] = from_word;
        ES_DBL:  pred_o[j] = from_dbl;
        default: pred_o[j] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/vec2pred_spread.sv
module vec2pred_spread
  import vp_pkg::*;
#(
  parameter int unsigned VLEN_BITS = 512
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [VLEN_BITS-1:0]   vec_in,
  input  logic [1:0]             elem_size,
  input  logic [2:0]             slice_idx,
  output logic                   done,
  output logic [VLEN_BITS/8-1:0] pred_out,
  output logic                   idx_illegal
);
  localparam int unsigned VBYTES = VLEN_BITS / 8;

  elem_size_e        es;
  logic [VBYTES-1:0] slice;
  logic [VBYTES-1:0] spread;
  logic              legal;

  logic [VBYTES-1:0] pred_d, pred_q;
  logic              ill_d, ill_q;
  logic              done_d, done_q;

  assign es = elem_size_e'(elem_size);

  vp_slice_shift #(.VLEN_BITS(VLEN_BITS)) u_shift (
    .vec_i   (vec_in),
    .es_i    (es),
    .idx_i   (slice_idx),
    .slice_o (slice),
    .legal_o (legal)
  );

  vp_bit_scatter #(.VBYTES(VBYTES)) u_scatter (
    .slice_i (slice),
    .es_i    (es),
    .pred_o  (spread)
  );

  // next state
  always_comb begin
    done_d = start;
    pred_d = pred_q;
    ill_d  = ill_q;
    if (start) begin
      pred_d = legal ? spread : '0;
      ill_d  = ~legal;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pred_q <= '0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (start) begin
        pred_q <= pred_d;
        ill_q  <= ill_d;
      end
    end
  end

  assign done        = done_q;
  assign pred_out    = pred_q;
  assign idx_illegal = ill_q;
endmodule

// File: rtl/vp_spread_chk.sv
module vp_spread_chk #(
  parameter int unsigned VLEN_BITS = 512
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic [VLEN_BITS-1:0]   vec_in,
  input logic [1:0]             elem_size,
  input logic [2:0]             slice_idx,
  input logic                   done,
  input logic [VLEN_BITS/8-1:0] pred_out,
  input logic                   idx_illegal
);
  localparam int unsigned VBYTES = VLEN_BITS / 8;
  localparam logic [VBYTES-1:0] HOLE_H = {(VBYTES/2){2'b10}};
  localparam logic [VBYTES-1:0] HOLE_W = {(VBYTES/4){4'b1110}};
  localparam logic [VBYTES-1:0] HOLE_D = {(VBYTES/8){8'hFE}};

  // R2
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  // R3
  byte_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && elem_size == 2'd0 && slice_idx == 3'd0)
      |=> (pred_out == $past(vec_in[VBYTES-1:0])));

  // R7
  half_holes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && elem_size == 2'd1) |=> ((pred_out & HOLE_H) == '0));

  // R7
  word_holes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && elem_size == 2'd2) |=> ((pred_out & HOLE_W) == '0));

  // R7
  dbl_holes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && elem_size == 2'd3) |=> ((pred_out & HOLE_D) == '0));

  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && idx_illegal) |-> (pred_out == '0));

  // R8
  byte_idx_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && elem_size == 2'd0 && slice_idx != 3'd0) |=> idx_illegal);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(pred_out) && $stable(idx_illegal)));
endmodule

bind vec2pred_spread vp_spread_chk #(.VLEN_BITS(VLEN_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .vec_in      (vec_in),
  .elem_size   (elem_size),
  .slice_idx   (slice_idx),
  .done        (done),
  .pred_out    (pred_out),
  .idx_illegal (idx_illegal)
);

// File: tb/vec2pred_spread_tb.sv
`timescale 1ns/1ps
module vec2pred_spread_tb;
  localparam int VA = 512;
  localparam int VB = 640;
  localparam int BA = VA / 8;
  localparam int BB = VB / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [VB-1:0] vec = '0;
  logic [1:0]    es = 2'd0;
  logic [2:0]    idx = 3'd0;

  logic          done_a, ill_a, done_b, ill_b;
  logic [BA-1:0] pred_a;
  logic [BB-1:0] pred_b;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit live = 1'b0;

  always #5 clk = ~clk;

  vec2pred_spread #(.VLEN_BITS(VA)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_in(vec[VA-1:0]),
    .elem_size(es), .slice_idx(idx), .done(done_a), .pred_out(pred_a),
    .idx_illegal(ill_a));

  vec2pred_spread #(.VLEN_BITS(VB)) u_dut_wide (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_in(vec),
    .elem_size(es), .slice_idx(idx), .done(done_b), .pred_out(pred_b),
    .idx_illegal(ill_b));

  // behavioural reference
  function automatic logic [BB-1:0] ref_pred(logic [VB-1:0] v, int e, int k, int nbytes);
    logic [BB-1:0] r = '0;
    int n;
    if (k >= (1 << e)) return r;
    n = nbytes >> e;
    for (int i = 0; i < n; i++) r[i << e] = v[k * n + i];
    return r;
  endfunction

  function automatic bit holes_clear(logic [BB-1:0] p, int e, int nbytes);
    for (int j = 0; j < nbytes; j++)
      if ((j % (1 << e)) != 0 && p[j]) return 1'b0;
    return 1'b1;
  endfunction

  logic          x_done;
  logic [BA-1:0] x_pred_a;
  logic [BB-1:0] x_pred_b;
  logic          x_ill;
  int            x_es;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_done <= 1'b0; x_pred_a <= '0; x_pred_b <= '0; x_ill <= 1'b0; x_es <= 0;
    end else begin
      x_done <= start;
      if (start) begin
        logic [BB-1:0] ra;
        ra = ref_pred(vec, int'(es), int'(idx), BA);
        x_pred_a <= ra[BA-1:0];
        x_pred_b <= ref_pred(vec, int'(es), int'(idx), BB);
        x_ill    <= (int'(idx) >= (1 << int'(es)));
        x_es     <= int'(es);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [BB-1:0] act, input logic [BB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic string size_tag(int e, bit ill, bit done_cycle);
    if (!done_cycle) return "R10";
    if (ill) return "R8";
    case (e)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      string t;
      t = size_tag(x_es, x_ill, x_done);
      chk(done_a == x_done && done_b == x_done, "R2", BB'(done_a), BB'(x_done));
      chk(pred_a == x_pred_a, t, BB'(pred_a), BB'(x_pred_a));
      chk(pred_b == x_pred_b, (t == "R6") ? "R9" : t, pred_b, x_pred_b);
      chk(ill_a == x_ill && ill_b == x_ill, x_done ? "R8" : "R10", BB'(ill_a), BB'(x_ill));
      if (x_done) begin
        chk(holes_clear(BB'(pred_a), x_es, BA) && holes_clear(pred_b, x_es, BB),
            "R7", pred_b, x_pred_b);
      end
    end
  end

  task automatic scramble();
    for (int w = 0; w < VB / 32; w++) vec[w*32 +: 32] = $urandom;
  endtask

  task automatic fire(input int e, input int k);
    @(negedge clk);
    start = 1'b1;
    es    = 2'(e);
    idx   = 3'(k);
  endtask

  task automatic idle();
    @(negedge clk);
    start = 1'b0;
    scramble();
    es  = 2'($urandom);
    idx = 3'($urandom);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(done_a == 1'b0 && done_b == 1'b0, "R1", BB'(done_a), '0);
    chk(pred_a == '0 && pred_b == '0, "R1", pred_b, '0);
    chk(ill_a == 1'b0 && ill_b == 1'b0, "R1", BB'(ill_a), '0);
    rst_n = 1'b1;
    live  = 1'b1;

    for (int rep = 0; rep < 6; rep++) begin
      for (int e = 0; e < 4; e++) begin
        for (int k = 0; k < 8; k++) begin
          case (rep)
            0: vec = '1;
            1: vec = {(VB/2){2'b10}};
            default: scramble();
          endcase
          fire(e, k);
          if (rep % 2 == 1) begin
            idle();
            idle();
          end
        end
      end
      idle();
    end

    // R9: straddling doubleword slice at 640 bits (bits 60..69)
    vec = '0;
    vec[69:60] = 10'b1011001101;
    fire(3, 6);
    idle();
    @(negedge clk);
    chk(pred_b[72] == 1'b1 && pred_b[64] == 1'b0 && pred_b[0] == 1'b1,
        "R9", pred_b, BB'(0));

    repeat (3) idle();
    live = 1'b0;
    finish_run();
  end
endmodule